// File: doc/BRIEF.md
# Dual-Mode Interval Timer

This block holds a set of countdown timer channels behind a small word-addressed register port. Each channel has a control word (prescale divisor, operating mode, count enable, interrupt enable), a 32-bit reload word and a 24-bit live count that software can read back. Once enabled, a channel's prescaler produces one tick every `divisor + 1` clock cycles, and each tick lowers the count by one. When the count reaches zero the channel sets its flag in a status word shared by all channels. An interrupt line per channel follows that flag, gated by the channel's interrupt enable.

There are two modes. In one-shot mode the channel halts at zero and its enable bit drops by itself. In periodic mode the channel reloads on the tick after zero and keeps running. A reload of all ones in periodic mode with interrupts masked gives a free-running 24-bit count that software can use as a time base. Software clears flags by writing ones to the status word.

Each channel runs a three-state machine. IDLE is stopped. COUNT is decrementing. WRAP is the one tick spent reloading in periodic mode. The transitions are:
- START (IDLE to COUNT) happens when software writes the enable bit to a stopped channel.
- RESTART (COUNT or WRAP to COUNT) happens on a reload write while the channel runs.
- STOP (any state to IDLE) happens on a control write with enable 0.
- HALT (COUNT to IDLE) happens on expiry in one-shot mode.
- EXPIRE_WRAP (COUNT to WRAP) happens on expiry in periodic mode.
- REFILL (WRAP to COUNT) happens on the next tick.

The register port runs a two-state machine. In ACCEPT the port has ready high. RESPOND lasts one cycle and drives the response.

Top module: `ivt_timer_top`

## Requirements
- R1: After reset, every control, reload, count and status word reads 0, `irq` is 0 and `req_ready` is 1.
- R2: Register map for channel c: control at word 4c, reload at 4c+1, count at 4c+2. The status word is at 4·NCH (8 with two channels). The control word's fields are: prescale divisor in bits 7:0, mode in bits 28:27, interrupt enable in bit 29, count enable in bit 30. All other control bits read 0. The mode field reads back exactly as written.
- R3: While a channel runs, its count drops by one every (divisor+1) cycles. The prescaler phase starts from zero at the write that starts or restarts the channel.
- R4: In one-shot mode (mode 00, and any mode other than 01), the tick that brings the count to 0 sets the channel's status flag. The same tick clears the count enable, and the count then stays at 0. With reload R ≥ 1 and divisor P, this happens R·(P+1) cycles after the enabling write.
- R5: In periodic mode (mode 01), expiry sets the flag and the count enable stays at 1. The next tick reloads the count, so with R ≥ 1 flags recur every (R+1)·(P+1) cycles.
- R6: `irq[c]` is 1 exactly while status bit c and the channel's interrupt enable are both 1. With interrupts masked the flag still sets, and raising the enable later asserts `irq[c]`.
- R7: Writing the status word clears each flag whose data bit is 1 (bit c is channel c) and leaves the others. Writing 0x1F clears all flags. An expiry in the same cycle wins over a clear.
- R8: Writing the reload word while a channel runs restarts the countdown from the new value with a fresh prescaler phase. When the channel is stopped, the write only stores the value.
- R9: A control write with enable 0 stops the channel and holds the count. A later control write with enable 1 reloads the count from the reload word.
- R10: The count is 24 bits. The reload word stores 32 bits, but only its low 24 bits are loaded, so a reload of 0xFFFFFFFF counts down from 0xFFFFFF.
- R11: Channels are independent. Activity on one channel never changes another channel's count, control word, flag or interrupt line.
- R12: A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` follows for exactly the next cycle, during which `req_ready` is low. Unmapped words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle (read data valid) |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bench builds the block with its defaults: two channels, a 24-bit count, an 8-bit divisor and 4-bit word addresses. With two channels, the shared status word, per-bit clears and cross-channel isolation can all be observed. Small reloads and divisors (reload 2 to 100, divisor 0 to 3) place one-shot expiry, periodic recurrence and the wrap tick within a few dozen cycles. The bench predicts count readback exactly from the cycle each request is accepted. The 24-bit truncation is visible at once through an all-ones reload. The full 2^24-tick wrap itself is not within reach at these sizes.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DATA_W = 32;

    // control word field positions
    localparam int EN_BIT  = 30;
    localparam int IE_BIT  = 29;
    localparam int MODE_HI = 28;
    localparam int MODE_LO = 27;

    localparam logic [1:0] MODE_PERIODIC = 2'b01;

    // per-channel word offsets
    localparam int REG_CTRL    = 0;
    localparam int REG_RLD     = 1;
    localparam int REG_CNT     = 2;
    localparam int REGS_PER_CH = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_WRAP  = 2'd2
    } ch_state_e;

    typedef enum logic {
        BUS_ACCEPT  = 1'b0,
        BUS_RESPOND = 1'b1
    } bus_state_e;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic             wrap;

    // >= keeps a lowered divisor from stalling the phase
    assign wrap = (phase_q >= div);
    assign tick = run && !restart && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run || wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              rld_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] rld_rd,
    output logic [CNT_W-1:0]  cnt_rd,
    output logic              en,
    output logic              ie,
    output logic              periodic,
    output logic              expire
);

    ch_state_e        state_q, state_d;
    logic [1:0]       mode_q;
    logic             ie_q;
    logic [PRE_W-1:0] pre_q;
    logic [DATA_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tick;
    logic             restart;
    logic             running;

    assign running  = (state_q != CH_IDLE);
    assign periodic = (mode_q == MODE_PERIODIC);

    ivt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (restart),
        .div     (pre_q),
        .tick    (tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: software writes take priority over a tick
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        restart = 1'b0;
        expire  = 1'b0;
        if (ctrl_we) begin
            if (!wdata[EN_BIT]) begin
                state_d = CH_IDLE;                 // STOP
                restart = 1'b1;
            end else if (state_q == CH_IDLE) begin
                state_d = CH_COUNT;                // START
                cnt_d   = rld_q[CNT_W-1:0];
                restart = 1'b1;
            end
        end else if (rld_we) begin
            if (running) begin
                state_d = CH_COUNT;                // RESTART
                cnt_d   = wdata[CNT_W-1:0];
                restart = 1'b1;
            end
        end else if (tick) begin
            unique case (state_q)
                CH_COUNT: begin
                    if (cnt_q <= CNT_W'(1)) begin
                        expire  = 1'b1;
                        cnt_d   = '0;
                        state_d = periodic ? CH_WRAP : CH_IDLE;  // EXPIRE_WRAP / HALT
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                CH_WRAP: begin
                    cnt_d   = rld_q[CNT_W-1:0];    // REFILL
                    state_d = CH_COUNT;
                end
                default: begin
                end
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ie_q   <= 1'b0;
            pre_q  <= '0;
            rld_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we) begin
                mode_q <= wdata[MODE_HI:MODE_LO];
                ie_q   <= wdata[IE_BIT];
                pre_q  <= wdata[PRE_W-1:0];
            end
            if (rld_we) begin
                rld_q <= wdata;
            end
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        en                      = running;
        ie                      = ie_q;
        cnt_rd                  = cnt_q;
        rld_rd                  = rld_q;
        ctrl_rd                 = '0;
        ctrl_rd[EN_BIT]         = running;
        ctrl_rd[IE_BIT]         = ie_q;
        ctrl_rd[MODE_HI:MODE_LO] = mode_q;
        ctrl_rd[PRE_W-1:0]      = pre_q;
    end

endmodule

// File: rtl/ivt_status.sv
module ivt_status #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_ev,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] ie,
    output logic [NCH-1:0] flags,
    output logic [NCH-1:0] irq
);

    logic [NCH-1:0] flags_q;
    logic [NCH-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_eff) | set_ev;   // set wins
        end
    end

    assign flags = flags_q;
    assign irq   = flags_q & ie;

endmodule

// File: rtl/ivt_bus.sv
module ivt_bus
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_data,
    output logic              req_ready,
    output logic              wr_stb,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    bus_state_e st_q, st_d;
    logic       accept;

    assign accept = req_valid && (st_q == BUS_ACCEPT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BUS_ACCEPT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_ACCEPT:  if (accept) st_d = BUS_RESPOND;
            BUS_RESPOND: st_d = BUS_ACCEPT;
            default:     st_d = BUS_ACCEPT;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (accept) begin
            rsp_rdata <= req_write ? '0 : rd_data;
        end
    end

    assign req_ready = (st_q == BUS_ACCEPT);
    assign rsp_valid = (st_q == BUS_RESPOND);
    assign wr_stb    = accept && req_write;

endmodule

// File: rtl/ivt_timer_top.sv
module ivt_timer_top
    import ivt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NCH-1:0]    irq
);

    localparam int STAT_ADDR = NCH * REGS_PER_CH;

    logic              wr_stb;
    logic              st_we;
    logic [DATA_W-1:0] rd_data;
    logic [NCH-1:0]    ch_ctl_we, ch_rld_we;
    logic [NCH-1:0]    ch_en, ch_ie, ch_periodic, ch_expire;
    logic [NCH-1:0]    flags_q;
    logic [DATA_W-1:0] ctrl_rd [NCH];
    logic [DATA_W-1:0] rld_rd  [NCH];
    logic [CNT_W-1:0]  cnt_rd  [NCH];

    ivt_bus u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_data   (rd_data),
        .req_ready (req_ready),
        .wr_stb    (wr_stb),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = c * REGS_PER_CH;

        assign ch_ctl_we[c] = wr_stb && (req_addr == ADDR_W'(BASE + REG_CTRL));
        assign ch_rld_we[c] = wr_stb && (req_addr == ADDR_W'(BASE + REG_RLD));

        ivt_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_we  (ch_ctl_we[c]),
            .rld_we   (ch_rld_we[c]),
            .wdata    (req_wdata),
            .ctrl_rd  (ctrl_rd[c]),
            .rld_rd   (rld_rd[c]),
            .cnt_rd   (cnt_rd[c]),
            .en       (ch_en[c]),
            .ie       (ch_ie[c]),
            .periodic (ch_periodic[c]),
            .expire   (ch_expire[c])
        );
    end

    assign st_we = wr_stb && (req_addr == ADDR_W'(STAT_ADDR));

    ivt_status #(.NCH(NCH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (ch_expire),
        .clr_we   (st_we),
        .clr_mask (req_wdata[NCH-1:0]),
        .ie       (ch_ie),
        .flags    (flags_q),
        .irq      (irq)
    );

    // read mux; unmapped words return zero
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (req_addr == ADDR_W'(c * REGS_PER_CH + REG_CTRL)) rd_data = ctrl_rd[c];
            if (req_addr == ADDR_W'(c * REGS_PER_CH + REG_RLD))  rd_data = rld_rd[c];
            if (req_addr == ADDR_W'(c * REGS_PER_CH + REG_CNT))  rd_data = DATA_W'(cnt_rd[c]);
        end
        if (req_addr == ADDR_W'(STAT_ADDR)) rd_data = DATA_W'(flags_q);
    end

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           st_we,
    input logic [31:0]    req_wdata,
    input logic [NCH-1:0] ch_en,
    input logic [NCH-1:0] ch_ie,
    input logic [NCH-1:0] ch_expire,
    input logic [NCH-1:0] ch_periodic,
    input logic [NCH-1:0] flags_q,
    input logic [NCH-1:0] irq
);

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);  // R12
    AST_NO_READY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);  // R12

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[c] && !ch_periodic[c]) |=> !ch_en[c]);  // R4
        AST_FLAG_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_expire[c] |=> flags_q[c]);  // R4
        AST_PERIODIC_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_expire[c] && ch_periodic[c]) |=> ch_en[c]);  // R5
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_ie[c] |-> !irq[c]);  // R6
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[c] && !(st_we && req_wdata[c])) |=> flags_q[c]);  // R7
    end

endmodule

bind ivt_timer_top ivt_timer_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .st_we       (st_we),
    .req_wdata   (req_wdata),
    .ch_en       (ch_en),
    .ch_ie       (ch_ie),
    .ch_expire   (ch_expire),
    .ch_periodic (ch_periodic),
    .flags_q     (flags_q),
    .irq         (irq)
);

// File: tb/sim_ivt_timer_top.sv
module sim_ivt_timer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  irq;

    int vectors = 0;
    int miscompares = 0;
    int edges = 0;
    bit done = 1'b0;

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    ivt_timer_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R12 unexpected response", 32'h1, 32'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                if (it.chk) check(rsp_rdata === it.exp, it.tag, rsp_rdata, it.exp);
            end
        end
    end

    task automatic issue(bit wr, logic [3:0] a, logic [31:0] d, output int acc);
        @(negedge clk);
        check(req_ready === 1'b1, "R12 ready before request", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        acc = edges;
        req_valid = 1'b0;
    endtask

    task automatic finish_x();
        @(negedge clk);
        check(rsp_valid === 1'b1 && req_ready === 1'b0, "R12 response cycle",
              {30'b0, rsp_valid, req_ready}, 32'h2);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, output int acc);
        item_t it;
        issue(1'b1, a, d, acc);
        it.chk = 1'b0; it.exp = '0; it.tag = "write";
        sbq.push_back(it);
        finish_x();
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        item_t it;
        int acc;
        issue(1'b0, a, 32'h0, acc);
        it.chk = 1'b1; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        finish_x();
    endtask

    // count read while running: ticks at edges S+(P+1)k that precede the accept edge
    task automatic rd_cnt(int ch, int r, int p, int s, string tag);
        item_t it;
        int acc;
        issue(1'b0, 4'(ch * 4 + 2), 32'h0, acc);
        it.chk = 1'b1;
        it.exp = 32'((r - (acc - 1 - s) / (p + 1)) & 32'h00FF_FFFF);
        it.tag = tag;
        sbq.push_back(it);
        finish_x();
    endtask

    task automatic wait_irq(int ch, output int e);
        e = -1;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            #1;
            if (irq[ch] === 1'b1) begin
                e = edges;
                break;
            end
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int s, d, e, e2, frozen, dummy;

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(irq === 2'b00, "R1 irq after reset", {30'b0, irq}, 32'h0);
        check(req_ready === 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
        rd(4'd0, 32'h0, "R1 ctrl0 reset");
        rd(4'd1, 32'h0, "R1 reload0 reset");
        rd(4'd2, 32'h0, "R1 count0 reset");
        rd(4'd6, 32'h0, "R1 count1 reset");
        rd(4'd8, 32'h0, "R1 status reset");

        // R2 field positions and reserved bits
        wr(4'd0, 32'h2800_0005, dummy);
        rd(4'd0, 32'h2800_0005, "R2 ctrl0 fields");
        wr(4'd4, 32'h9FFF_FF33, dummy);
        rd(4'd4, 32'h1800_0033, "R2 ctrl1 reserved bits");
        wr(4'd4, 32'h0, dummy);
        rd(4'd4, 32'h0, "R2 ctrl1 cleared");

        // R3 / R4 one-shot, reload 10, divisor 3
        wr(4'd1, 32'd10, dummy);
        wr(4'd0, 32'h6000_0003, s);
        rd_cnt(0, 10, 3, s, "R3 count early");
        idle(5);
        rd_cnt(0, 10, 3, s, "R3 count after ticks");
        wait_irq(0, e);
        check(e == s + 40, "R4 one-shot expiry cycle", 32'(e - s), 32'd40);
        rd(4'd0, 32'h2000_0003, "R4 enable cleared");
        rd(4'd2, 32'h0, "R4 count holds 0");
        rd(4'd8, 32'h1, "R4 flag set");

        // R7 write-one-to-clear
        wr(4'd8, 32'h2, dummy);
        rd(4'd8, 32'h1, "R7 other bit kept");
        @(negedge clk);
        check(irq[0] === 1'b1, "R7 irq0 kept", {31'b0, irq[0]}, 32'h1);
        wr(4'd8, 32'h1, dummy);
        rd(4'd8, 32'h0, "R7 bit0 cleared");
        @(negedge clk);
        check(irq[0] === 1'b0, "R7 irq0 dropped", {31'b0, irq[0]}, 32'h0);

        // R5 periodic on channel 1, reload 5, divisor 3
        wr(4'd5, 32'd5, dummy);
        wr(4'd4, 32'h6800_0003, s);
        wait_irq(1, e);
        check(e == s + 20, "R5 first periodic expiry", 32'(e - s), 32'd20);
        wr(4'd8, 32'h1F, dummy);
        wait_irq(1, e2);
        check(e2 == e + 24, "R5 periodic recurrence", 32'(e2 - e), 32'd24);
        rd(4'd4, 32'h6800_0003, "R5 enable stays");
        wr(4'd4, 32'h0, dummy);
        wr(4'd8, 32'h1F, dummy);
        rd(4'd8, 32'h0, "R7 all cleared by 0x1F");

        // R6 masked interrupt
        wr(4'd1, 32'd2, dummy);
        wr(4'd0, 32'h4000_0000, s);
        idle(4);
        rd(4'd8, 32'h1, "R6 flag set while masked");
        check(irq[0] === 1'b0, "R6 irq masked", {31'b0, irq[0]}, 32'h0);
        rd(4'd0, 32'h0, "R4 mode00 halts");
        wr(4'd0, 32'h2000_0000, dummy);
        @(negedge clk);
        check(irq[0] === 1'b1, "R6 irq after enable", {31'b0, irq[0]}, 32'h1);
        wr(4'd8, 32'h1F, dummy);
        @(negedge clk);
        check(irq === 2'b00, "R6 irq after clear", {30'b0, irq}, 32'h0);

        // R9 stop holds, restart reloads
        wr(4'd1, 32'd100, dummy);
        wr(4'd0, 32'h4000_0001, s);
        rd_cnt(0, 100, 1, s, "R3 divisor 1 count");
        idle(10);
        wr(4'd0, 32'h0000_0001, d);
        frozen = 100 - (d - 1 - s) / 2;
        idle(6);
        rd(4'd2, 32'(frozen), "R9 count held");
        idle(4);
        rd(4'd2, 32'(frozen), "R9 count still held");
        wr(4'd0, 32'h4000_0001, s);
        rd_cnt(0, 100, 1, s, "R9 re-enable reloads");

        // R8 reload write while running
        idle(4);
        wr(4'd1, 32'd50, s);
        rd_cnt(0, 50, 1, s, "R8 restart from new reload");
        idle(8);
        rd_cnt(0, 50, 1, s, "R8 fresh phase");
        wr(4'd0, 32'h0, dummy);

        // R10 all-ones reload, free running
        wr(4'd5, 32'hFFFF_FFFF, dummy);
        rd(4'd5, 32'hFFFF_FFFF, "R10 reload stores 32 bits");
        wr(4'd4, 32'h4800_0000, s);
        rd_cnt(1, 32'h00FF_FFFF, 0, s, "R10 count 24-bit");
        idle(20);
        rd_cnt(1, 32'h00FF_FFFF, 0, s, "R10 count free running");
        check(irq[1] === 1'b0, "R10 irq1 masked", {31'b0, irq[1]}, 32'h0);
        wr(4'd4, 32'h0, dummy);

        // R11 independence
        wr(4'd8, 32'h1F, dummy);
        wr(4'd1, 32'd3, dummy);
        wr(4'd0, 32'h6000_0000, s);
        wait_irq(0, e);
        check(e == s + 3, "R4 expiry divisor 0", 32'(e - s), 32'd3);
        rd(4'd8, 32'h1, "R11 only ch0 flag");
        check(irq[1] === 1'b0, "R11 irq1 quiet", {31'b0, irq[1]}, 32'h0);
        rd(4'd4, 32'h0, "R11 ctrl1 untouched");
        wr(4'd8, 32'h1F, dummy);

        // R12 unmapped words
        rd(4'hF, 32'h0, "R12 unmapped read F");
        rd(4'd3, 32'h0, "R12 unmapped read 3");
        wr(4'hF, 32'hFFFF_FFFF, dummy);
        rd(4'd0, 32'h2000_0000, "R12 unmapped write no effect");
        rd(4'd8, 32'h0, "R12 status unchanged");

        idle(4);
        check(sbq.size() == 0, "R12 all responses seen", 32'(sbq.size()), 32'h0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule